// File: doc/BRIEF.md
# Vertex Out-Degree Counter and Rank Seeder

This block prepares the per-vertex tables that an iterative link-ranking engine reads. After a start strobe it first zeroes its internal out-degree store. It then takes a stream of directed edges (source, destination) and adds one to the out-degree of each edge's source vertex. When the beat marked last has been taken, it walks the vertices once, from 0 up to N-1, where N is the vertex count captured at start. For each vertex it emits one write that carries two values: a scaling constant (1 - alpha) / out-degree, and a seed rank 1/N that is the same for every vertex.

All values are unsigned Q1.31 (32 bits, 2^31 is 1.0). One restoring divider, shared by all divisions and taking one quotient bit per cycle, computes first 1/N and then each vertex's constant. A vertex with no outgoing edges gets a constant of 0 and no division is run for it. The edge input is valid/ready. A beat transfers on a clock edge at which both `edge_valid` and `edge_ready` are high. The sender holds `edge_src`, `edge_dst` and `edge_last` stable while `edge_valid` is high and `edge_ready` is low. The block holds `edge_ready` low while it clears and while it sweeps, and holds it high for the whole edge phase, so back-pressure appears only at phase boundaries. The output write strobe has no back-pressure. Start, vertex count and done are plain level or pulse pins.

Top module: `vtx_seed_init`

## Requirements
- R1: A `start` pulse while the block is idle begins a clear pass that zeroes all 2^VID_W degree entries. `edge_ready` is low for exactly 2^VID_W cycles after the edge that samples `start`, and then goes high. After reset, `edge_ready`, `wr_en` and `done` are low.
- R2: Each transferred edge with `edge_src` < N and `edge_src` != `edge_dst` adds exactly 1 to the out-degree of `edge_src`.
- R3: A transferred edge that is a self edge (`edge_src` == `edge_dst`) or whose source is N or more is accepted but changes no degree.
- R4: After the beat with `edge_last` = 1 transfers, `edge_ready` stays low until `done` has pulsed.
- R5: Every sweep write carries `wr_rank` = floor(2^31 / N), where N is `vtx_count` captured at start (1 to 2^VID_W).
- R6: For a vertex with out-degree d > 0, `wr_const` = floor(C / d), where C = 322122547 (0.15 in Q1.31).
- R7: For a vertex with out-degree 0, `wr_const` = 0.
- R8: The sweep makes exactly N writes, each a one-cycle `wr_en` pulse, with `wr_addr` going 0, 1, ... N-1 in order.
- R9: `done` pulses high for one cycle, in the cycle right after the last write. No write occurs in that cycle.
- R10: A `start` pulse while a run is in progress is ignored: degrees already counted are kept and `edge_ready` does not drop.
- R11: A new run after `done` counts degrees from zero, with no carry-over from the previous run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (honoured only when idle) |
| vtx_count | input | VID_W+1 | Vertex count N, sampled with start |
| edge_valid | input | 1 | Edge beat valid |
| edge_ready | output | 1 | Block takes an edge beat |
| edge_src | input | VID_W | Edge source vertex |
| edge_dst | input | VID_W | Edge destination vertex |
| edge_last | input | 1 | Final edge beat of the stream |
| wr_en | output | 1 | Vertex table write strobe |
| wr_addr | output | VID_W | Vertex index of the write |
| wr_const | output | FIX_W | (1 - alpha) / out-degree, Q1.31 |
| wr_rank | output | FIX_W | Seed rank 1/N, Q1.31 |
| done | output | 1 | One-cycle pulse after the last write |

## Verification
The hardest situation to reach from the ports is a `start` pulse that arrives in the middle of an edge stream. A block that wrongly honoured it would clear the degrees already counted, and that would show up only much later as wrong constants. The bench inserts such a pulse in an idle gap of a full-size run with 64 vertices and then checks both the next ready level and every constant. A second hard case is a vertex whose degree was high in an earlier run and is zero in the next one. Back-to-back runs with different N and different edge sets cover it, together with self edges, out-of-range sources and the N = 1 case, where the seed rank is exactly 1.0.

// File: rtl/vsi_pkg.sv
package vsi_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_CLEAR,
    S_ACCEPT,
    S_RANK_GO,
    S_RANK_WAIT,
    S_VTX,
    S_VTX_WAIT,
    S_FIN
  } vsi_state_e;
endpackage

// File: rtl/vsi_deg_store.sv
module vsi_deg_store #(
  parameter int AW = 6,
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          clr,
  input  logic          inc,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  assign rd_data = mem[addr];

  always_ff @(posedge clk) begin
    if (clr) begin
      mem[addr] <= '0;
    end else if (inc) begin
      mem[addr] <= rd_data + 1'b1;
    end
  end

  p_clear_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> mem[$past(addr)] == '0);

  p_incr_by_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr) |=> mem[$past(addr)] == DW'($past(rd_data) + 1'b1));
endmodule

// File: rtl/vsi_restore_div.sv
module vsi_restore_div #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         valid,
  output logic [W-1:0] quotient
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]   q_q, r_q, d_q, num_q;
  logic [CW-1:0]  cnt_q;
  logic [W:0]     trial;
  logic           fits;
  logic [2*W-1:0] prod_chk;

  always_comb begin
    trial    = {r_q, q_q[W-1]};
    fits     = trial >= {1'b0, d_q};
    prod_chk = (2*W)'(q_q) * (2*W)'(d_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_q   <= '0;
      r_q   <= '0;
      d_q   <= '0;
      num_q <= '0;
      cnt_q <= '0;
      valid <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (go && cnt_q == '0) begin
        q_q   <= dividend;
        r_q   <= '0;
        d_q   <= divisor;
        num_q <= dividend;
        cnt_q <= CW'(W);
      end else if (cnt_q != '0) begin
        r_q   <= fits ? W'(trial - {1'b0, d_q}) : trial[W-1:0];
        q_q   <= {q_q[W-2:0], fits};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) valid <= 1'b1;
      end
    end
  end

  assign busy     = cnt_q != '0;
  assign quotient = q_q;

  p_go_when_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(go && busy));

  p_quot_exact_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && d_q != '0) |-> (prod_chk <= (2*W)'(num_q)) &&
                             ((2*W)'(num_q) - prod_chk < (2*W)'(d_q)));
endmodule

// File: rtl/vtx_seed_init.sv
module vtx_seed_init
  import vsi_pkg::*;
#(
  parameter int VID_W = 6,
  parameter int FIX_W = 32,
  parameter logic [FIX_W-1:0] CONST_NUM = 32'd322122547
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [VID_W:0]     vtx_count,
  input  logic               edge_valid,
  output logic               edge_ready,
  input  logic [VID_W-1:0]   edge_src,
  input  logic [VID_W-1:0]   edge_dst,
  input  logic               edge_last,
  output logic               wr_en,
  output logic [VID_W-1:0]   wr_addr,
  output logic [FIX_W-1:0]   wr_const,
  output logic [FIX_W-1:0]   wr_rank,
  output logic               done
);
  localparam int DEPTH = 1 << VID_W;
  localparam int DEG_W = 2 * VID_W;
  localparam int CNT_W = VID_W + 1;
  localparam logic [FIX_W-1:0] ONE_FX = FIX_W'(1) << (FIX_W - 1);

  vsi_state_e         state_q;
  logic [CNT_W-1:0]   n_q;
  logic [VID_W-1:0]   idx_q;
  logic [FIX_W-1:0]   rank_q;

  logic [VID_W-1:0]   deg_addr;
  logic               deg_clr, deg_inc;
  logic [DEG_W-1:0]   deg_rd;

  logic               div_go, div_busy, div_valid;
  logic [FIX_W-1:0]   div_num, div_den, div_quot;

  logic               take, counts, last_vtx;

  assign edge_ready = (state_q == S_ACCEPT);
  assign take       = edge_valid && edge_ready;
  assign counts     = take && ({1'b0, edge_src} < n_q) && (edge_src != edge_dst);
  assign last_vtx   = ({1'b0, idx_q} == n_q - 1'b1);

  always_comb begin
    deg_addr = (state_q == S_ACCEPT) ? edge_src : idx_q;
    deg_clr  = (state_q == S_CLEAR);
    deg_inc  = counts;
    div_go   = (state_q == S_RANK_GO) || (state_q == S_VTX && deg_rd != '0);
    div_num  = (state_q == S_RANK_GO) ? ONE_FX : CONST_NUM;
    div_den  = (state_q == S_RANK_GO) ? FIX_W'(n_q) : FIX_W'(deg_rd);
  end

  vsi_deg_store #(.AW(VID_W), .DW(DEG_W)) u_deg (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (deg_addr),
    .clr     (deg_clr),
    .inc     (deg_inc),
    .rd_data (deg_rd)
  );

  vsi_restore_div #(.W(FIX_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (div_go),
    .dividend (div_num),
    .divisor  (div_den),
    .busy     (div_busy),
    .valid    (div_valid),
    .quotient (div_quot)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      n_q      <= '0;
      idx_q    <= '0;
      rank_q   <= '0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_const <= '0;
      wr_rank  <= '0;
      done     <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      done  <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          if (start) begin
            n_q     <= vtx_count;
            idx_q   <= '0;
            state_q <= S_CLEAR;
          end
        end
        S_CLEAR: begin
          idx_q <= idx_q + 1'b1;
          if (idx_q == VID_W'(DEPTH - 1)) state_q <= S_ACCEPT;
        end
        S_ACCEPT: begin
          if (take && edge_last) state_q <= S_RANK_GO;
        end
        S_RANK_GO: begin
          state_q <= S_RANK_WAIT;
        end
        S_RANK_WAIT: begin
          if (div_valid) begin
            rank_q  <= div_quot;
            idx_q   <= '0;
            state_q <= S_VTX;
          end
        end
        S_VTX: begin
          if (deg_rd == '0) begin
            wr_en    <= 1'b1;
            wr_addr  <= idx_q;
            wr_const <= '0;
            wr_rank  <= rank_q;
            if (last_vtx) state_q <= S_FIN;
            else          idx_q   <= idx_q + 1'b1;
          end else begin
            state_q <= S_VTX_WAIT;
          end
        end
        S_VTX_WAIT: begin
          if (div_valid) begin
            wr_en    <= 1'b1;
            wr_addr  <= idx_q;
            wr_const <= div_quot;
            wr_rank  <= rank_q;
            if (last_vtx) begin
              state_q <= S_FIN;
            end else begin
              idx_q   <= idx_q + 1'b1;
              state_q <= S_VTX;
            end
          end
        end
        S_FIN: begin
          done    <= 1'b1;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  p_quiet_after_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && edge_last) |=> !edge_ready);

  p_addr_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ({1'b0, wr_addr} < n_q));

  p_addr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en)) |-> wr_addr == $past(wr_addr) + 1'b1);

  p_rank_same_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en)) |-> wr_rank == $past(wr_rank));

  p_done_after_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(wr_en) && !wr_en);

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/tb_vtx_seed_init.sv
`timescale 1ns/1ps
module tb_vtx_seed_init;
  localparam int VID_W = 6;
  localparam int FIX_W = 32;
  localparam int DEPTH = 1 << VID_W;
  localparam longint CNUM = 322122547;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [VID_W:0] vtx_count = '0;
  logic edge_valid = 1'b0;
  logic edge_ready;
  logic [VID_W-1:0] edge_src = '0;
  logic [VID_W-1:0] edge_dst = '0;
  logic edge_last = 1'b0;
  logic wr_en;
  logic [VID_W-1:0] wr_addr;
  logic [FIX_W-1:0] wr_const;
  logic [FIX_W-1:0] wr_rank;
  logic done;

  always #4 clk = ~clk;

  vtx_seed_init #(.VID_W(VID_W), .FIX_W(FIX_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .vtx_count(vtx_count),
    .edge_valid(edge_valid), .edge_ready(edge_ready), .edge_src(edge_src),
    .edge_dst(edge_dst), .edge_last(edge_last), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_const(wr_const), .wr_rank(wr_rank), .done(done)
  );

  typedef struct { int a; longint c; longint r; } wexp_t;

  int     total = 0;
  int     bad = 0;
  int     mdeg [DEPTH];
  int     cur_n = 0;
  wexp_t  expq [$];
  bit     quiet = 1'b0;
  bit     prev_wr = 1'b0;
  bit     prev_done = 1'b0;
  int     done_cnt = 0;
  string  run_tag = "";

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s%s %s actual=%0d expected=%0d", req, run_tag, what, act, exp);
    end
  endtask

  // reference model compared on every clock
  always @(negedge clk) begin
    if (rst_n) begin
      if (quiet && edge_ready) check(1'b0, "R4", "ready high during sweep", 1, 0);
      if (wr_en) begin
        if (expq.size() == 0) begin
          check(1'b0, "R8", "unexpected write addr", longint'(wr_addr), -1);
        end else begin
          wexp_t e;
          e = expq.pop_front();
          check(int'(wr_addr) == e.a, "R8", "write addr", longint'(wr_addr), e.a);
          check(longint'(wr_const) == e.c, (e.c == 0) ? "R7" : "R6", "const",
                longint'(wr_const), e.c);
          check(longint'(wr_rank) == e.r, "R5", "rank", longint'(wr_rank), e.r);
        end
      end
      if (done) begin
        check(prev_wr && !wr_en, "R9", "done placement", longint'(prev_wr), 1);
        check(!prev_done, "R9", "done width", 2, 1);
        check(expq.size() == 0, "R8", "writes missing", expq.size(), 0);
        done_cnt++;
        quiet = 1'b0;
      end
      prev_wr   = wr_en;
      prev_done = done;
    end
  end

  task automatic build_exp();
    for (int v = 0; v < cur_n; v++) begin
      wexp_t e;
      e.a = v;
      e.c = (mdeg[v] == 0) ? 0 : CNUM / mdeg[v];
      e.r = (64'd1 << 31) / cur_n;
      expq.push_back(e);
    end
  endtask

  task automatic start_run(int n);
    int cnt;
    for (int v = 0; v < DEPTH; v++) mdeg[v] = 0;
    cur_n = n;
    @(negedge clk);
    vtx_count = (VID_W+1)'(n);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cnt = 0;
    while (!edge_ready) begin
      cnt++;
      @(negedge clk);
    end
    check(cnt == DEPTH, "R1", "clear pass length", cnt, DEPTH);
  endtask

  // called at a negedge; returns at the following negedge
  task automatic send_edge(int s, int d, bit last);
    bit r;
    edge_valid = 1'b1;
    edge_src   = VID_W'(s);
    edge_dst   = VID_W'(d);
    edge_last  = last;
    forever begin
      r = edge_ready;
      @(posedge clk);
      if (r) break;
      @(negedge clk);
    end
    if (s < cur_n && s != d) mdeg[s]++;   // R2, R3
    if (last) begin
      quiet = 1'b1;
      build_exp();
    end
    @(negedge clk);
    edge_valid = 1'b0;
    edge_last  = 1'b0;
  endtask

  task automatic wait_done();
    int seen;
    seen = done_cnt;
    while (done_cnt == seen) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!edge_ready && !wr_en && !done, "R1", "reset outputs",
          longint'({edge_ready, wr_en, done}), 0);

    // run A: N=5, mixed degrees, self edge and out-of-range source (R2, R3, R7)
    start_run(5);
    send_edge(0, 1, 0);
    send_edge(0, 2, 0);
    @(negedge clk);
    send_edge(0, 3, 0);
    send_edge(1, 2, 0);
    send_edge(4, 4, 0);   // R3 self edge
    send_edge(2, 0, 0);
    send_edge(7, 1, 0);   // R3 source beyond N
    send_edge(3, 0, 0);
    send_edge(3, 1, 1);
    wait_done();

    // run B: fresh degrees, vertex 0 now has none (R11)
    run_tag = "/R11";
    start_run(3);
    send_edge(1, 0, 0);
    send_edge(1, 2, 0);
    send_edge(2, 1, 1);
    wait_done();

    // run C: single vertex, rank exactly 1.0 (R5)
    run_tag = "/N1";
    start_run(1);
    send_edge(0, 0, 1);
    wait_done();

    // run D: full depth with a start pulse mid-stream (R10)
    run_tag = "/R10";
    start_run(DEPTH);
    for (int v = 0; v < DEPTH / 2; v++) send_edge(v, (v + 1) % DEPTH, 0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(edge_ready == 1'b1, "R10", "ready after stray start", longint'(edge_ready), 1);
    for (int v = DEPTH / 2; v < DEPTH; v++) send_edge(v, (v + 1) % DEPTH, 0);
    for (int v = 0; v < DEPTH; v += 2) send_edge(v, (v + 2) % DEPTH, 0);
    send_edge(5, 9, 1);
    wait_done();

    repeat (3) @(negedge clk);
    check(!edge_ready && !wr_en && !done, "R9", "idle after done",
          longint'({edge_ready, wr_en, done}), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule